// File: doc/BRIEF.md
# Supply Monitor Reset Controller

This block is the digital side of a supply-voltage supervisor. A comparator outside the block, already synchronized to `clk`, reports on `supply_ok` whether the supply sits above its threshold. The block holds the monitor's enable, models the monitor's turn-on settling time with a cycle counter, and decides when to raise a registered system reset request `sys_rst_req`. Software reaches it through a small synchronous register bus. Two registers are visible. One is the monitor control register, with the enable and the live supply status. The other is the reset-source register, with the monitor's select bit and a power-on flag.

The monitor can only reset the system when it is both enabled and selected as a reset source. Selecting it before it has settled, or while it is off, is treated as a fault and resets the system at once. A reset caused by the supply or by a premature select clears the select bit, so software has to arm the monitor again. The enable bit survives every reset except power-on. Because of this, a warm reset keeps the monitor running and keeps it settled.

There is no data stream at the edge of this block. Every pin is a plain control or status level, so there is no valid/ready handshake and no back-pressure.

Top module: `supmon_rst_ctrl`

## Requirements
- R1: While `por_n` is low and after it rises, the enable is 1, the select bit is 0, the power-on flag is 1 and `sys_rst_req` is 0. Register map: control at address 0 (enable at bit 7, status at bit 6). Reset-source register at address 1 (select at bit 1, power-on flag at bit 0, read-only).
- R2: A cycle with `other_rst` high leaves the enable unchanged. It clears the select bit and the power-on flag.
- R3: Control bit 6 reads `supply_ok` while enabled and 0 while disabled. Bits 5..0 of the control register read 0, and writes to them have no effect. Unmapped bits of the reset-source register read 0.
- R4: The monitor counts as settled once the enable has been 1 for `SETTLE_CYC` consecutive clock edges. Clearing the enable clears the settled state.
- R5: A write of 1 to the select bit while the monitor is disabled or not yet settled raises `sys_rst_req` in the next cycle and leaves the select bit at 0.
- R6: While enabled and selected, `supply_ok` low raises `sys_rst_req` in the next cycle. It clears the select bit and keeps the enable.
- R7: A supply-low reset stays asserted while `supply_ok` stays low. It drops `MIN_PULSE` cycles after the last edge at which `supply_ok` was low, so a low lasting L edges gives a pulse of L+`MIN_PULSE`-1 cycles.
- R8: A premature-select reset produces a pulse of exactly `MIN_PULSE` cycles.
- R9: While the enable is 0, `supply_ok` has no effect on `sys_rst_req`, even if the select bit is still 1.
- R10: If a supply-low trigger and a write setting the select bit land on the same edge, the trigger wins and the select bit ends at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| other_rst | input | 1 | Synchronous non-power-on reset (software, pin, watchdog) |
| supply_ok | input | 1 | Synchronized comparator output, 1 = supply above threshold |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `addr` |
| sys_rst_req | output | 1 | Registered system reset request |

## Verification
Two functions can land on the same clock edge. The first is the supply-low trigger, which clears the select bit. The second is a software write that sets the same bit. The bench lowers `supply_ok` and issues the select write on the same negative edge while the monitor is settled and already selected. It then judges the result in two ways. It reads the select bit back as 0, and it checks through the pulse scoreboard that the reset pulse length matches the supply-low formula and not the premature-select length.

// File: rtl/supmon_pkg.sv
package supmon_pkg;
  localparam int CTRL_ADDR = 0;
  localparam int SRC_ADDR  = 1;
  localparam int EN_BIT    = 7;
  localparam int STAT_BIT  = 6;
  localparam int SEL_BIT   = 1;
  localparam int PORF_BIT  = 0;
  localparam int NTRIG     = 2;
  localparam int TRIG_LOW  = 0;
  localparam int TRIG_PREM = 1;
endpackage

// File: rtl/supmon_regs.sv
module supmon_regs
  import supmon_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              other_rst,
  input  logic              supply_ok,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              settled,
  input  logic              trig_low,
  output logic              prem,
  output logic              en_q,
  output logic              sel_q,
  output logic [7:0]        rd_data
);
  logic wr_ctrl, wr_src, porf_q;

  assign wr_ctrl = wr_en && (addr == ADDR_W'(CTRL_ADDR));
  assign wr_src  = wr_en && (addr == ADDR_W'(SRC_ADDR));
  // arming the monitor before it is on and settled is a fault
  assign prem    = wr_src && wr_data[SEL_BIT] && !(en_q && settled);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      en_q   <= 1'b1;
      sel_q  <= 1'b0;
      porf_q <= 1'b1;
    end else begin
      if (wr_ctrl) en_q <= wr_data[EN_BIT];
      if (other_rst) begin
        sel_q  <= 1'b0;
        porf_q <= 1'b0;
      end else if (trig_low || prem) begin
        sel_q <= 1'b0;
      end else if (wr_src) begin
        sel_q <= wr_data[SEL_BIT];
      end
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (addr == ADDR_W'(CTRL_ADDR)) begin
      rd_data[EN_BIT]   = en_q;
      rd_data[STAT_BIT] = en_q && supply_ok;
    end else if (addr == ADDR_W'(SRC_ADDR)) begin
      rd_data[SEL_BIT]  = sel_q;
      rd_data[PORF_BIT] = porf_q;
    end
  end
endmodule

// File: rtl/supmon_settle.sv
module supmon_settle #(
  parameter int SETTLE_CYC = 100
) (
  input  logic clk,
  input  logic por_n,
  input  logic en,
  output logic settled
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_q   <= '0;
      settled <= 1'b0;
    end else if (!en) begin
      cnt_q   <= '0;
      settled <= 1'b0;
    end else if (!settled) begin
      if (cnt_q == LAST) settled <= 1'b1;
      else               cnt_q   <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/supmon_pulse.sv
module supmon_pulse
  import supmon_pkg::*;
#(
  parameter int MIN_PULSE = 16
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic [NTRIG-1:0] trig,
  input  logic             supply_ok,
  output logic             hold_q,
  output logic             rst_q
);
  localparam int PW = $clog2(MIN_PULSE + 1);
  localparam logic [PW-1:0] RELOAD = PW'(MIN_PULSE - 1);

  logic [NTRIG-1:0] trig_any;
  logic             reload;
  logic [PW-1:0]    cnt_q;

  genvar g;
  generate
    for (g = 0; g < NTRIG; g++) begin : g_or
      if (g == 0) begin : g_first
        assign trig_any[g] = trig[g];
      end else begin : g_rest
        assign trig_any[g] = trig_any[g-1] | trig[g];
      end
    end
  endgenerate

  assign reload = trig_any[NTRIG-1] || (hold_q && !supply_ok);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      hold_q <= 1'b0;
      cnt_q  <= '0;
      rst_q  <= 1'b0;
    end else begin
      if (trig[TRIG_LOW])  hold_q <= 1'b1;
      else if (supply_ok)  hold_q <= 1'b0;
      if (reload) begin
        cnt_q <= RELOAD;
        rst_q <= 1'b1;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end else begin
        rst_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/supmon_rst_ctrl.sv
module supmon_rst_ctrl
  import supmon_pkg::*;
#(
  parameter int ADDR_W     = 2,
  parameter int SETTLE_CYC = 100,
  parameter int MIN_PULSE  = 16
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              other_rst,
  input  logic              supply_ok,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  output logic              sys_rst_req
);
  logic en_q, sel_q, settled_q, hold_q, prem, trig_low;
  logic [NTRIG-1:0] trig;

  assign trig_low        = en_q && sel_q && !supply_ok;
  assign trig[TRIG_LOW]  = trig_low;
  assign trig[TRIG_PREM] = prem;

  supmon_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .por_n(por_n), .other_rst(other_rst), .supply_ok(supply_ok),
    .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .settled(settled_q),
    .trig_low(trig_low), .prem(prem), .en_q(en_q), .sel_q(sel_q),
    .rd_data(rd_data)
  );

  supmon_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .por_n(por_n), .en(en_q), .settled(settled_q)
  );

  supmon_pulse #(.MIN_PULSE(MIN_PULSE)) u_pulse (
    .clk(clk), .por_n(por_n), .trig(trig), .supply_ok(supply_ok),
    .hold_q(hold_q), .rst_q(sys_rst_req)
  );
endmodule

// File: rtl/supmon_chk.sv
module supmon_chk
  import supmon_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              por_n,
  input logic              other_rst,
  input logic              supply_ok,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [7:0]        wr_data,
  input logic [7:0]        rd_data,
  input logic              sys_rst_req,
  input logic              en,
  input logic              sel,
  input logic              settled,
  input logic              hold
);
  // R5
  prem_rst_chk: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && addr == ADDR_W'(SRC_ADDR) && wr_data[SEL_BIT] && !(en && settled))
    |=> (sys_rst_req && !sel));

  // R6
  low_rst_chk: assert property (@(posedge clk) disable iff (!por_n)
    (en && sel && !supply_ok && !wr_en) |=> (sys_rst_req && !sel && en));

  // R2
  warm_keep_en_chk: assert property (@(posedge clk) disable iff (!por_n)
    (other_rst && !(wr_en && addr == ADDR_W'(CTRL_ADDR))) |=> ($stable(en) && !sel));

  // R7
  hold_low_chk: assert property (@(posedge clk) disable iff (!por_n)
    (hold && !supply_ok) |=> sys_rst_req);

  // R8
  min_width_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sys_rst_req) |=> sys_rst_req);

  // R3
  status_off_chk: assert property (@(posedge clk) disable iff (!por_n)
    (addr == ADDR_W'(CTRL_ADDR) && !en) |-> (rd_data[STAT_BIT] == 1'b0 && rd_data[5:0] == 6'd0));
endmodule

bind supmon_rst_ctrl supmon_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .por_n(por_n), .other_rst(other_rst), .supply_ok(supply_ok),
  .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .sys_rst_req(sys_rst_req), .en(en_q), .sel(sel_q), .settled(settled_q),
  .hold(hold_q)
);

// File: tb/tb_supmon_rst_ctrl.sv
`timescale 1ns/1ps
module tb_supmon_rst_ctrl;
  localparam int ADDR_W = 2;
  localparam int SETTLE = 100;
  localparam int MINP   = 16;

  logic clk = 1'b0, por_n = 1'b0, other_rst = 1'b0, supply_ok = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic sys_rst_req;

  int n_tests = 0, n_fail = 0;
  int exp_q[$];
  int run_len = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  supmon_rst_ctrl #(.ADDR_W(ADDR_W), .SETTLE_CYC(SETTLE), .MIN_PULSE(MINP)) dut (
    .clk(clk), .por_n(por_n), .other_rst(other_rst), .supply_ok(supply_ok),
    .addr(addr), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .sys_rst_req(sys_rst_req)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: measure each reset pulse and compare with the scoreboard queue
  always @(negedge clk) begin
    if (por_n && !done) begin
      if (sys_rst_req) run_len++;
      else if (run_len > 0) begin
        if (exp_q.size() == 0) chk("R9 unexpected pulse", run_len, 0);
        else chk("R7/R8 pulse length", run_len, exp_q.pop_front());
        run_len = 0;
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    addr = ADDR_W'(a); wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    addr = ADDR_W'(a);
    #1;
    d = int'(rd_data);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    done = 1'b1;
    summary();
  end

  initial begin
    int v;
    idle(3);
    // R1: values during power-on reset
    chk("R1 rst_req during por", int'(sys_rst_req), 0);
    rd(0, v); chk("R1 ctrl during por", v, 8'hC0);
    por_n = 1'b1;
    idle(1);
    rd(0, v); chk("R1 ctrl after por", v, 8'hC0);
    rd(1, v); chk("R1 src after por", v, 8'h01);
    chk("R1 rst_req after por", int'(sys_rst_req), 0);

    // R5 + R8: select while still settling
    exp_q.push_back(MINP);
    wr(1, 8'h02);
    chk("R5 rst next cycle", int'(sys_rst_req), 1);
    rd(1, v); chk("R5 select stays 0", v & 2, 0);
    idle(MINP + 4);

    // R3: reserved bits ignored, status follows supply
    wr(0, 8'hBF);
    rd(0, v); chk("R3 reserved ignored", v, 8'hC0);
    @(negedge clk); supply_ok = 1'b0;
    rd(0, v); chk("R3 status low", v, 8'h80);
    @(negedge clk); supply_ok = 1'b1;

    // R2: warm reset keeps enable, clears select and flag
    @(negedge clk); other_rst = 1'b1;
    @(negedge clk); other_rst = 1'b0;
    rd(0, v); chk("R2 enable kept", v, 8'hC0);
    rd(1, v); chk("R2 flag cleared", v, 8'h00);

    // R3/R5: disabled reads status 0, select while off faults
    wr(0, 8'h00);
    rd(0, v); chk("R3 disabled status", v, 8'h00);
    @(negedge clk); other_rst = 1'b1;
    @(negedge clk); other_rst = 1'b0;
    rd(0, v); chk("R2 enable 0 kept", v, 8'h00);
    exp_q.push_back(MINP);
    wr(1, 8'h02);
    chk("R5 rst while disabled", int'(sys_rst_req), 1);
    idle(MINP + 4);

    // R4: premature before SETTLE edges, accepted after
    wr(0, 8'h80);
    idle(SETTLE / 2);
    exp_q.push_back(MINP);
    wr(1, 8'h02);
    chk("R4 still settling", int'(sys_rst_req), 1);
    idle(SETTLE / 2 + 20);
    wr(1, 8'h02);
    chk("R4 settled no rst", int'(sys_rst_req), 0);
    rd(1, v); chk("R4 select set", v & 2, 2);

    // R6 + R7: supply low for 5 edges
    exp_q.push_back(5 + MINP - 1);
    @(negedge clk); supply_ok = 1'b0;
    @(negedge clk);
    chk("R6 rst on low", int'(sys_rst_req), 1);
    rd(1, v); chk("R6 select cleared", v & 2, 0);
    rd(0, v); chk("R6 enable kept", v & 8'h80, 8'h80);
    idle(4);
    supply_ok = 1'b1;
    idle(MINP + 4);

    // R9: disabled monitor ignores supply although still selected
    wr(1, 8'h02);
    wr(0, 8'h00);
    @(negedge clk); supply_ok = 1'b0;
    idle(5);
    chk("R9 no rst when disabled", int'(sys_rst_req), 0);
    supply_ok = 1'b1;
    wr(1, 8'h00);

    // R10: supply-low trigger and select write on same edge
    wr(0, 8'h80);
    idle(SETTLE + 10);
    wr(1, 8'h02);
    chk("R10 arm no rst", int'(sys_rst_req), 0);
    exp_q.push_back(3 + MINP - 1);
    @(negedge clk);
    supply_ok = 1'b0; addr = ADDR_W'(1); wr_data = 8'h02; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R10 rst on collision", int'(sys_rst_req), 1);
    rd(1, v); chk("R10 select cleared", v & 2, 0);
    idle(2);
    supply_ok = 1'b1;
    idle(MINP + 4);

    chk("R7/R8 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    summary();
  end
endmodule